// File: doc/BRIEF.md
# Indexed Codec Host Register Interface

This block is the host-facing register front end of an audio codec. A host on an 8-bit parallel bus sees four direct registers, selected by a 2-bit address: an index pointer (address 0), an indirect data window (address 1), a read-only status byte (address 2) and a playback sample byte (address 3). The index pointer selects one of 32 indirect configuration registers, and the data window reads or writes that register. Only a chosen subset of the 32 slots is backed by storage.

Beyond plain storage, the block enforces several access rules. The sample-format and interface-configuration registers are protected by a mode-change bit in the index pointer, except for the two stream-enable bits. The index pointer and the data window lock to a fixed value during a post-reset initialization window and during software power-down. The status byte reports a pending interrupt and whether the playback byte has been consumed. Playback and capture DMA requests from the datapath can be held off while an interrupt is pending. The converters, the sample path and the DMA engine are outside the block. They appear only as request, consume, interrupt and mute signals.

Top module: `codec_host_regs`

## Requirements
- R1: After reset is released, an initialization window lasts INIT_CYCLES clock cycles. During the window, addresses 0 and 1 read 80h. After the window, address 0 reads 40h: MCE is set, TRD is clear and the pointer is 0.
- R2: While initialization is active, or while pwrMode equals 2'b01, host writes to addresses 0 and 1 have no effect, and both addresses read 80h.
- R3: The index byte holds MCE in bit 6, TRD in bit 5 and the indirect pointer in bits 4..0. Bit 7 reads 0 outside the lockout. Address 1 reads and writes the indirect register the pointer selects. With the default IMPL_MASK, slots 0-15 and 28 are implemented. Every other slot reads 00h and discards writes.
- R4: While compatMode is 1, pointer bit 4 is stored and read as 0, so only slots 0-15 are reachable.
- R5: Writes to slots 8 and 28 take effect only while MCE is 1.
- R6: In slot 9, bit 0 (playback enable) and bit 1 (capture enable) are writable at any time. Bits 7..2 of slot 9 change only while MCE is 1.
- R7: dacMute equals MCE.
- R8: Status bit 0 (INT) is set on the edge where irqReq is 1. A write of any value to address 2 clears it. If both happen in the same cycle, the set wins.
- R9: irqOut is 1 exactly when INT is 1 and bit 1 of slot 10 (interrupt enable) is 1.
- R10: Status bit 1 (PRDY) is 1 after reset. A write to address 3 clears it and a playConsume pulse sets it. If both happen in the same cycle, the write wins. Address 3 and playData both return the last byte written to address 3. Status bits 7..2 read 0.
- R11: playDrq equals playReq and capDrq equals capReq while TRD is 0. While TRD is 1, each request passes only while INT is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 2 | Direct register select |
| hostWrEn | input | 1 | Host write strobe, one cycle per write |
| hostWrData | input | 8 | Host write byte |
| hostRdData | output | 8 | Read byte for hostAddr (combinational) |
| compatMode | input | 1 | Reduced mode: only 16 indirect slots reachable |
| pwrMode | input | 2 | Power-mode field; 2'b01 is software power-down |
| irqReq | input | 1 | Interrupt event from the codec core |
| playConsume | input | 1 | One-cycle pulse: playback byte consumed |
| playReq | input | 1 | Raw playback DMA request |
| capReq | input | 1 | Raw capture DMA request |
| playData | output | 8 | Last playback byte written |
| playDrq | output | 1 | Gated playback DMA request |
| capDrq | output | 1 | Gated capture DMA request |
| dacMute | output | 1 | Converter mute |
| irqOut | output | 1 | Interrupt line |

## Verification
A host write, an irqReq event or a playConsume pulse changes state on the clock edge where it is sampled. Because reads are combinational, the change is visible one edge after the stimulus. The bench drives each stimulus on a falling edge, holds it across one rising edge, and samples after the following falling edge. The DMA requests, dacMute and irqOut are combinational from state and inputs, so the bench checks them in the same half cycle in which it changes a request input. The indirect bank is swept over all 32 slots with MCE set and with MCE clear, and the bench computes the expected contents from the protection rules.

// File: rtl/codec_host_pkg.sv
package codec_host_pkg;

  localparam int NUM_IDX = 32;
  localparam int IDX_W   = 5;

  localparam int SLOT_FMT_A = 8;
  localparam int SLOT_CFG   = 9;
  localparam int SLOT_PIN   = 10;
  localparam int SLOT_FMT_B = 28;
  localparam int IEN_BIT    = 1;

  localparam logic [7:0] LOCK_READ  = 8'h80;
  localparam logic [7:0] CFG_FREE   = 8'h03;

  typedef enum logic [1:0] {
    REG_INDEX  = 2'd0,
    REG_DATA   = 2'd1,
    REG_STATUS = 2'd2,
    REG_PLAY   = 2'd3
  } hostReg_e;

  typedef struct packed {
    logic wrIndex;
    logic wrData;
    logic wrStatus;
    logic wrPlay;
    logic lockout;
  } hostStrobe_t;

  // Bits of an indirect slot that a host write may change under the current MCE.
  function automatic logic [7:0] slotWriteMask(input int slot, input logic mce);
    if (slot == SLOT_FMT_A || slot == SLOT_FMT_B) return mce ? 8'hFF : 8'h00;
    else if (slot == SLOT_CFG)                    return mce ? 8'hFF : CFG_FREE;
    else                                          return 8'hFF;
  endfunction

endpackage

// File: rtl/codec_host_ctrl.sv
module codec_host_ctrl
  import codec_host_pkg::*;
#(
  parameter int INIT_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWrEn,
  input  logic [1:0]  hostAddr,
  input  logic [1:0]  pwrMode,
  output hostStrobe_t strb
);

  localparam int CNT_W = $clog2(INIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(INIT_CYCLES - 1);

  logic [CNT_W-1:0] initCnt;
  logic             initActive;
  logic             pwrDown;
  logic             lockout;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      initCnt    <= '0;
      initActive <= 1'b1;
    end else if (initActive) begin
      initCnt <= initCnt + 1'b1;
      if (initCnt == LAST_CNT) initActive <= 1'b0;
    end
  end

  assign pwrDown = (pwrMode == 2'b01);
  assign lockout = initActive | pwrDown;

  always_comb begin
    strb          = '0;
    strb.lockout  = lockout;
    strb.wrIndex  = hostWrEn && (hostAddr == REG_INDEX)  && !lockout;
    strb.wrData   = hostWrEn && (hostAddr == REG_DATA)   && !lockout;
    strb.wrStatus = hostWrEn && (hostAddr == REG_STATUS);
    strb.wrPlay   = hostWrEn && (hostAddr == REG_PLAY);
  end

  // R1: the init window cannot end before the count is reached
  assert_init_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (initActive && initCnt != LAST_CNT) |=> initActive);

  // R1: once ended, initialization does not return without reset
  assert_init_done_R1: assert property (@(posedge clk) disable iff (!rstN)
    !initActive |=> !initActive);

endmodule

// File: rtl/codec_host_datapath.sv
module codec_host_datapath
  import codec_host_pkg::*;
#(
  parameter logic [NUM_IDX-1:0] IMPL_MASK = 32'h1000_FFFF
) (
  input  logic        clk,
  input  logic        rstN,
  input  hostStrobe_t strb,
  input  logic [1:0]  hostAddr,
  input  logic [7:0]  hostWrData,
  input  logic        compatMode,
  input  logic        irqReq,
  input  logic        playConsume,
  input  logic        playReq,
  input  logic        capReq,
  output logic [7:0]  hostRdData,
  output logic [7:0]  idxState,
  output logic [7:0]  playData,
  output logic        playDrq,
  output logic        capDrq,
  output logic        dacMute,
  output logic        irqOut
);

  logic             mce;
  logic             trd;
  logic [IDX_W-1:0] ptr;
  logic [IDX_W-1:0] effPtr;
  logic [7:0]       bank [NUM_IDX];
  logic             intFlag;
  logic             prdy;
  logic [7:0]       playQ;

  // index pointer
  assign effPtr = compatMode ? {1'b0, ptr[IDX_W-2:0]} : ptr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mce <= 1'b1;
      trd <= 1'b0;
      ptr <= '0;
    end else if (strb.wrIndex) begin
      mce <= hostWrData[6];
      trd <= hostWrData[5];
      ptr <= {hostWrData[IDX_W-1] & ~compatMode, hostWrData[IDX_W-2:0]};
    end
  end

  assign idxState = {1'b0, mce, trd, effPtr};

  // indirect bank
  for (genvar g = 0; g < NUM_IDX; g++) begin : gBank
    if (IMPL_MASK[g]) begin : gImpl
      logic [7:0] slotQ;
      logic [7:0] wMask;
      logic       hit;
      assign wMask = slotWriteMask(g, mce);
      assign hit   = strb.wrData && (effPtr == IDX_W'(g));
      always_ff @(posedge clk) begin
        if (!rstN)    slotQ <= 8'h00;
        else if (hit) slotQ <= (slotQ & ~wMask) | (hostWrData & wMask);
      end
      assign bank[g] = slotQ;
    end else begin : gNone
      assign bank[g] = 8'h00;
    end
  end

  // interrupt and playback status
  always_ff @(posedge clk) begin
    if (!rstN)              intFlag <= 1'b0;
    else if (irqReq)        intFlag <= 1'b1;
    else if (strb.wrStatus) intFlag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prdy  <= 1'b1;
      playQ <= 8'h00;
    end else if (strb.wrPlay) begin
      prdy  <= 1'b0;
      playQ <= hostWrData;
    end else if (playConsume) begin
      prdy  <= 1'b1;
    end
  end

  assign playData = playQ;
  assign irqOut   = intFlag & bank[SLOT_PIN][IEN_BIT];
  assign dacMute  = mce;
  assign playDrq  = playReq & (~trd | ~intFlag);
  assign capDrq   = capReq  & (~trd | ~intFlag);

  // read mux
  always_comb begin
    unique case (hostAddr)
      REG_INDEX:  hostRdData = strb.lockout ? LOCK_READ : idxState;
      REG_DATA:   hostRdData = strb.lockout ? LOCK_READ : bank[effPtr];
      REG_STATUS: hostRdData = {6'b0, prdy, intFlag};
      default:    hostRdData = playQ;
    endcase
  end

  // R8: an interrupt event is visible after the edge
  assert_int_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |=> intFlag);

  // R8: a status write without a new event clears INT
  assert_int_clr_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrStatus && !irqReq) |=> !intFlag);

  // R10: a playback write always leaves the byte pending
  assert_prdy_clr_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrPlay |=> !prdy);

  // R5: format slot 8 holds when MCE is clear
  assert_fmt_lock_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrData && !mce && effPtr == IDX_W'(SLOT_FMT_A)) |=> $stable(bank[SLOT_FMT_A]));

  // R6: protected bits of slot 9 hold when MCE is clear
  assert_cfg_lock_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrData && !mce && effPtr == IDX_W'(SLOT_CFG)) |=> $stable(bank[SLOT_CFG][7:2]));

  // R4: in compatibility mode the pointer never reaches the upper half
  assert_compat_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrIndex && compatMode) |=> !ptr[IDX_W-1]);

endmodule

// File: rtl/codec_host_regs.sv
module codec_host_regs
  import codec_host_pkg::*;
#(
  parameter int INIT_CYCLES = 16,
  parameter logic [NUM_IDX-1:0] IMPL_MASK = 32'h1000_FFFF
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] hostAddr,
  input  logic       hostWrEn,
  input  logic [7:0] hostWrData,
  output logic [7:0] hostRdData,
  input  logic       compatMode,
  input  logic [1:0] pwrMode,
  input  logic       irqReq,
  input  logic       playConsume,
  input  logic       playReq,
  input  logic       capReq,
  output logic [7:0] playData,
  output logic       playDrq,
  output logic       capDrq,
  output logic       dacMute,
  output logic       irqOut
);

  hostStrobe_t strb;
  logic [7:0]  idxState;

  codec_host_ctrl #(.INIT_CYCLES(INIT_CYCLES)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostWrEn (hostWrEn),
    .hostAddr (hostAddr),
    .pwrMode  (pwrMode),
    .strb     (strb)
  );

  codec_host_datapath #(.IMPL_MASK(IMPL_MASK)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .hostAddr    (hostAddr),
    .hostWrData  (hostWrData),
    .compatMode  (compatMode),
    .irqReq      (irqReq),
    .playConsume (playConsume),
    .playReq     (playReq),
    .capReq      (capReq),
    .hostRdData  (hostRdData),
    .idxState    (idxState),
    .playData    (playData),
    .playDrq     (playDrq),
    .capDrq      (capDrq),
    .dacMute     (dacMute),
    .irqOut      (irqOut)
  );

  // R2: an index write under lockout leaves the pointer untouched
  assert_lock_idx_R2: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostAddr == 2'd0 && strb.lockout && !$rose(compatMode) && !$fell(compatMode))
      |=> $stable(idxState));

  // R7: mute follows MCE
  assert_mute_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.lockout && hostAddr == 2'd0) |-> (dacMute == hostRdData[6]));

endmodule

// File: tb/codec_host_regs_test.sv
module codec_host_regs_test;

  localparam int INIT = 16;
  localparam logic [31:0] IMPL = 32'h1000_FFFF;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] hostAddr = 2'd0;
  logic       hostWrEn = 1'b0;
  logic [7:0] hostWrData = 8'h00;
  logic [7:0] hostRdData;
  logic       compatMode = 1'b0;
  logic [1:0] pwrMode = 2'b00;
  logic       irqReq = 1'b0;
  logic       playConsume = 1'b0;
  logic       playReq = 1'b0;
  logic       capReq = 1'b0;
  logic [7:0] playData;
  logic       playDrq, capDrq, dacMute, irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] model [32];

  codec_host_regs #(.INIT_CYCLES(INIT), .IMPL_MASK(IMPL)) uut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .compatMode(compatMode),
    .pwrMode(pwrMode), .irqReq(irqReq), .playConsume(playConsume),
    .playReq(playReq), .capReq(capReq), .playData(playData), .playDrq(playDrq),
    .capDrq(capDrq), .dacMute(dacMute), .irqOut(irqOut)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostWrData = d; hostWrEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    hostAddr = a;
    #1 d = hostRdData;
  endtask

  task automatic pulseIrq();
    @(negedge clk); irqReq = 1'b1;
    @(negedge clk); irqReq = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] d;
    logic [7:0] idxHold;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 and R2 during initialization
    hostRead(2'd0, rd); check("R1 index during init", rd, 8'h80);
    hostRead(2'd1, rd); check("R1 data during init", rd, 8'h80);
    hostWrite(2'd0, 8'h25);
    repeat (INIT + 2) @(negedge clk);
    hostRead(2'd0, rd); check("R1 R2 index after init", rd, 8'h40);
    hostRead(2'd2, rd); check("R10 status after reset", rd, 8'h02);
    check("R7 mute with MCE set", {7'b0, dacMute}, 8'h01);

    // R3 sweep with MCE set
    for (int i = 0; i < 32; i++) begin
      d = 8'(i * 37 + 11);
      hostWrite(2'd0, 8'h40 | 8'(i));
      hostWrite(2'd1, d);
      model[i] = IMPL[i] ? d : 8'h00;
    end
    for (int i = 0; i < 32; i++) begin
      hostWrite(2'd0, 8'h40 | 8'(i));
      hostRead(2'd1, rd);
      check($sformatf("R3 slot %0d with MCE", i), rd, model[i]);
    end

    // R5 R6 sweep with MCE clear
    for (int i = 0; i < 32; i++) begin
      d = ~8'(i * 37 + 11);
      hostWrite(2'd0, 8'(i));
      hostWrite(2'd1, d);
      if (!IMPL[i])               model[i] = 8'h00;
      else if (i == 8 || i == 28) model[i] = model[i];
      else if (i == 9)            model[i] = (model[i] & 8'hFC) | (d & 8'h03);
      else                        model[i] = d;
    end
    for (int i = 0; i < 32; i++) begin
      hostWrite(2'd0, 8'(i));
      hostRead(2'd1, rd);
      check($sformatf("R5 R6 R3 slot %0d without MCE", i), rd, model[i]);
    end
    check("R7 mute with MCE clear", {7'b0, dacMute}, 8'h00);

    // R4 compatibility mode
    compatMode = 1'b1;
    hostWrite(2'd0, 8'h13);
    hostRead(2'd0, rd); check("R4 pointer bit 4 forced", rd, 8'h03);
    hostWrite(2'd1, 8'h5A);
    model[3] = 8'h5A;
    compatMode = 1'b0;
    hostRead(2'd0, rd); check("R4 pointer stored without bit 4", rd, 8'h03);
    hostRead(2'd1, rd); check("R4 write reached slot 3", rd, model[3]);

    // R8 R9 interrupt
    hostWrite(2'd0, 8'd10);
    hostWrite(2'd1, 8'h02);
    pulseIrq();
    hostRead(2'd2, rd); check("R8 INT set", rd, 8'h03);
    check("R9 irqOut enabled", {7'b0, irqOut}, 8'h01);
    hostWrite(2'd1, 8'h00);
    check("R9 irqOut disabled", {7'b0, irqOut}, 8'h00);
    hostRead(2'd2, rd); check("R9 INT kept while disabled", rd, 8'h03);
    hostWrite(2'd2, 8'h5C);
    hostRead(2'd2, rd); check("R8 INT cleared by write", rd, 8'h02);
    @(negedge clk);
    hostAddr = 2'd2; hostWrData = 8'hFF; hostWrEn = 1'b1; irqReq = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0; irqReq = 1'b0;
    hostRead(2'd2, rd); check("R8 set wins over clear", rd, 8'h03);
    hostWrite(2'd2, 8'h00);

    // R11 request gating, exhaustive
    for (int t = 0; t < 2; t++) begin
      for (int iv = 0; iv < 2; iv++) begin
        hostWrite(2'd0, {2'b00, 1'(t), 5'd10});
        if (iv == 1) pulseIrq(); else hostWrite(2'd2, 8'h00);
        for (int pr = 0; pr < 2; pr++) begin
          for (int cr = 0; cr < 2; cr++) begin
            @(negedge clk);
            playReq = 1'(pr); capReq = 1'(cr);
            #1;
            check($sformatf("R11 playDrq t%0d i%0d", t, iv), {7'b0, playDrq},
                  {7'b0, 1'(pr) & (t == 0 || iv == 0)});
            check($sformatf("R11 capDrq t%0d i%0d", t, iv), {7'b0, capDrq},
                  {7'b0, 1'(cr) & (t == 0 || iv == 0)});
          end
        end
      end
    end
    playReq = 1'b0; capReq = 1'b0;
    hostWrite(2'd2, 8'h00);

    // R10 playback byte
    hostWrite(2'd3, 8'h77);
    hostRead(2'd2, rd); check("R10 PRDY cleared", rd, 8'h00);
    hostRead(2'd3, rd); check("R10 playback readback", rd, 8'h77);
    check("R10 playData", playData, 8'h77);
    @(negedge clk); playConsume = 1'b1;
    @(negedge clk); playConsume = 1'b0;
    hostRead(2'd2, rd); check("R10 PRDY set by consume", rd, 8'h02);
    @(negedge clk);
    hostAddr = 2'd3; hostWrData = 8'h19; hostWrEn = 1'b1; playConsume = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0; playConsume = 1'b0;
    hostRead(2'd2, rd); check("R10 write wins over consume", rd, 8'h00);

    // R2 power-down
    hostWrite(2'd0, 8'h0A);
    idxHold = 8'h0A;
    pwrMode = 2'b01;
    hostRead(2'd0, rd); check("R2 index in power-down", rd, 8'h80);
    hostRead(2'd1, rd); check("R2 data in power-down", rd, 8'h80);
    hostWrite(2'd0, 8'h35);
    hostWrite(2'd1, 8'hEE);
    pwrMode = 2'b10;
    hostRead(2'd0, rd); check("R2 index write ignored", rd, idxHold);
    hostRead(2'd1, rd); check("R2 data write ignored", rd, 8'h00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule